// File: doc/BRIEF.md
# Trigger-Tower Pulse Filter and Energy Encoder

This block handles one calorimeter trigger-tower channel. Digitized pulse samples arrive at four times the beam-crossing rate. The block keeps every second sample and shapes that stream with an eight-tap programmable FIR filter. A three-point peak search then ties the pulse energy to a single crossing, so a slow-rising pulse that passes threshold on its leading edge is not credited to an earlier crossing. The peak value is turned into an 8-bit transverse-energy code through a writable table. Each crossing produces one code with a one-clock valid pulse.

The whole chain runs on one clock at the sample rate. A free-running two-bit phase counter, cleared by reset, produces the half-rate and crossing-rate enables. Filter coefficients and table entries are loaded through a small address/data/write-enable port. The table is a single memory with a registered read, so it fits a block RAM.

Top module: `tt_filter_chain`

## Requirements
- R1: While `rst` is high at a clock edge, `e_valid` and `energy` are 0 after that edge. Reset also empties the tap delay line and the peak history to zero, so an output that follows reset shows no trace of samples seen before it.
- R2: Number the clock edges from the first edge with `rst` low as edge 0; edge k has phase k mod 4. `smp_in` enters the delay line only on even-phase edges. Its value on odd-phase edges has no effect on any output.
- R3: On each odd-phase edge the filter forms y = sum over k = 0..7 of c[k]*x[k], arithmetically shifted right by `FIR_SHIFT` (default 3). Here x[0] is the newest captured sample (unsigned) and c[k] is a 6-bit two's-complement coefficient.
- R4: A negative filter sum yields y = 0. A shifted value above 2047 yields y = 2047.
- R5: On each phase-0 edge the detector judges the filter output produced on the previous phase-1 edge, call it y[m]. That output is a peak when y[m] > y[m-1] and y[m] >= y[m+1], where y[m-1] and y[m+1] are its two neighbouring filter outputs.
- R6: When the judged output is not a peak, `energy` is 0 in that crossing's valid cycle, even if table entry 0 is nonzero.
- R7: When it is a peak, `energy` equals the table entry at address y[m] in that crossing's valid cycle.
- R8: With `cfg_we` high, `cfg_addr[11]`=0 writes `cfg_wdata` to table entry `cfg_addr[10:0]`, and `cfg_addr[11]`=1 writes `cfg_wdata[5:0]` to coefficient c[`cfg_addr[2:0]`]. A coefficient write is used from the next odd-phase edge after it. A table write is used by lookups on later edges. A lookup on the same edge as a write reads the old entry.
- R9: `e_valid` is high for exactly one clock in every four: the clock after each phase-2 edge. The code it carries comes from the filter output computed five edges earlier.
- R10: `energy` is 0 whenever `e_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the crossing rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 10 | Unsigned ADC sample, one per clock |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 12 | Bit 11 selects coefficient (1) or table (0) |
| cfg_wdata | input | 8 | Table entry or coefficient (low 6 bits) |
| energy | output | 8 | Transverse-energy code of the crossing |
| e_valid | output | 1 | One-clock pulse once per crossing |

## Verification
The assertions assume that reset is applied before the first useful cycle and that the phase counter starts from zero. Valid placement, tap and filter holding, and the nonzero peak value are checked relative to that count. The peak check also relies on filter outputs being unsigned, so a strictly rising middle point is never zero. The stimulus changes `smp_in` on every clock and feeds noise on odd phases. It holds reset long enough to clear the whole pipeline, and it writes coefficients and table entries at chosen edges, including ones that coincide with filter evaluations.

// File: rtl/tt_filt_pkg.sv
package tt_filt_pkg;
  typedef enum logic [1:0] {
    PH_CAP0 = 2'd0,
    PH_EVAL0 = 2'd1,
    PH_CAP1 = 2'd2,
    PH_EVAL1 = 2'd3
  } phase_t;
endpackage

// File: rtl/tt_phase_gen.sv
module tt_phase_gen
  import tt_filt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t ph,
  output logic   smp_en,
  output logic   fir_en,
  output logic   pk_en
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_CAP0;
    else     ph <= phase_t'(ph + 2'd1);
  end

  always_comb begin
    smp_en = (ph == PH_CAP0) || (ph == PH_CAP1);
    fir_en = (ph == PH_EVAL0) || (ph == PH_EVAL1);
    pk_en  = (ph == PH_CAP0);
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_EVAL1) |=> (ph == PH_CAP0)); // R2
endmodule

// File: rtl/tt_fir.sv
module tt_fir #(
  parameter int SAMPLE_W  = 10,
  parameter int NTAPS     = 8,
  parameter int COEF_W    = 6,
  parameter int FILT_W    = 11,
  parameter int FIR_SHIFT = 3,
  localparam int IDX_W    = $clog2(NTAPS),
  localparam int PROD_W   = SAMPLE_W + 1 + COEF_W,
  localparam int ACC_W    = PROD_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_en,
  input  logic                fir_en,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                coef_we,
  input  logic [IDX_W-1:0]    coef_idx,
  input  logic [COEF_W-1:0]   coef_data,
  output logic [FILT_W-1:0]   fir_q
);
  logic [SAMPLE_W-1:0]      taps [NTAPS];
  logic signed [COEF_W-1:0] coef [NTAPS];
  logic signed [PROD_W-1:0] prod [NTAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  shifted;
  logic [FILT_W-1:0]        sat_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
    end else if (smp_en) begin
      taps[0] <= smp_in;
      for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NTAPS; i++)
      if (coef_we && coef_idx == IDX_W'(i)) coef[i] <= coef_data;
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_mul
    assign prod[g] = $signed({1'b0, taps[g]}) * coef[g];
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAPS; i++)
      acc = acc + {{(ACC_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
    shifted = acc >>> FIR_SHIFT;
    if (acc[ACC_W-1])                    sat_val = '0;
    else if (|shifted[ACC_W-1:FILT_W])   sat_val = '1;
    else                                 sat_val = shifted[FILT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         fir_q <= '0;
    else if (fir_en) fir_q <= sat_val;
  end

  AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(taps[0]) && $stable(taps[NTAPS-1]))); // R2
  AST_FIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fir_en |=> $stable(fir_q)); // R3
endmodule

// File: rtl/tt_peak_det.sv
module tt_peak_det #(
  parameter int FILT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fir_en,
  input  logic              pk_en,
  input  logic [FILT_W-1:0] fir_q,
  output logic              pk_vld,
  output logic              pk_hit,
  output logic [FILT_W-1:0] pk_val
);
  logic [FILT_W-1:0] hist0, hist1;
  logic              is_peak;

  assign is_peak = (hist0 > hist1) && (hist0 >= fir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist0 <= '0;
      hist1 <= '0;
    end else if (fir_en) begin
      hist1 <= hist0;
      hist0 <= fir_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_vld <= 1'b0;
      pk_hit <= 1'b0;
      pk_val <= '0;
    end else begin
      pk_vld <= pk_en;
      if (pk_en) begin
        pk_hit <= is_peak;
        pk_val <= is_peak ? hist0 : '0;
      end
    end
  end

  AST_PEAK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pk_hit |-> (pk_val != '0)); // R5
endmodule

// File: rtl/tt_et_lut.sv
module tt_et_lut #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tt_filter_chain.sv
module tt_filter_chain
  import tt_filt_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int NTAPS     = 8,
  parameter int COEF_W    = 6,
  parameter int FILT_W    = 11,
  parameter int E_W       = 8,
  parameter int FIR_SHIFT = 3,
  localparam int IDX_W    = $clog2(NTAPS),
  localparam int CFG_AW   = FILT_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [E_W-1:0]      cfg_wdata,
  output logic [E_W-1:0]      energy,
  output logic                e_valid
);
  phase_t            ph;
  logic              smp_en, fir_en, pk_en;
  logic [FILT_W-1:0] fir_q;
  logic              pk_vld, pk_hit;
  logic [FILT_W-1:0] pk_val;
  logic [E_W-1:0]    lut_rd;
  logic              hit_d, vld_d;
  logic              coef_we, lut_we;

  assign coef_we = cfg_we &&  cfg_addr[CFG_AW-1];
  assign lut_we  = cfg_we && !cfg_addr[CFG_AW-1];

  tt_phase_gen u_phase (
    .clk(clk), .rst(rst), .ph(ph),
    .smp_en(smp_en), .fir_en(fir_en), .pk_en(pk_en)
  );

  tt_fir #(
    .SAMPLE_W(SAMPLE_W), .NTAPS(NTAPS), .COEF_W(COEF_W),
    .FILT_W(FILT_W), .FIR_SHIFT(FIR_SHIFT)
  ) u_fir (
    .clk(clk), .rst(rst), .smp_en(smp_en), .fir_en(fir_en),
    .smp_in(smp_in), .coef_we(coef_we),
    .coef_idx(cfg_addr[IDX_W-1:0]), .coef_data(cfg_wdata[COEF_W-1:0]),
    .fir_q(fir_q)
  );

  tt_peak_det #(.FILT_W(FILT_W)) u_peak (
    .clk(clk), .rst(rst), .fir_en(fir_en), .pk_en(pk_en),
    .fir_q(fir_q), .pk_vld(pk_vld), .pk_hit(pk_hit), .pk_val(pk_val)
  );

  tt_et_lut #(.AW(FILT_W), .DW(E_W)) u_lut (
    .clk(clk), .we(lut_we), .waddr(cfg_addr[FILT_W-1:0]),
    .wdata(cfg_wdata), .raddr(pk_val), .rdata(lut_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_d   <= 1'b0;
      vld_d   <= 1'b0;
      energy  <= '0;
      e_valid <= 1'b0;
    end else begin
      hit_d   <= pk_hit;
      vld_d   <= pk_vld;
      energy  <= (vld_d && hit_d) ? lut_rd : '0;
      e_valid <= vld_d;
    end
  end

  AST_VALID_PHASE: assert property (@(posedge clk) disable iff (rst)
    e_valid |-> (ph == PH_EVAL1)); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    e_valid |=> !e_valid); // R9
  AST_ENERGY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !e_valid |-> (energy == '0)); // R10
endmodule

// File: tb/tt_filter_chain_tb.sv
module tt_filter_chain_tb;
  localparam int SHIFT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] smp_in = '0;
  logic       cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] energy;
  logic       e_valid;

  always #2 clk = ~clk;

  tt_filter_chain u_dut (
    .clk(clk), .rst(rst), .smp_in(smp_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .energy(energy), .e_valid(e_valid)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  int mph = 0;
  int xs [8];
  int cm [8];
  int lut_m [2048];
  int y_cur = 0, y_prev = 0, y_old = 0;
  int pk_v = 0, pk_f = 0, pk_a = 0;
  int s_v = 0, s_f = 0, s_rd = 0;
  int exp_v = 0, exp_e = 0;
  int m_rst = 1;
  int started = 0;
  int peaks_seen = 0;

  function automatic int filt(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int acc;
    int s;
    acc = cm[0]*a0 + cm[1]*a1 + cm[2]*a2 + cm[3]*a3
        + cm[4]*a4 + cm[5]*a5 + cm[6]*a6 + cm[7]*a7;
    if (acc < 0) return 0;               // R4
    s = acc >>> SHIFT;
    return (s > 2047) ? 2047 : s;        // R4
  endfunction

  always @(posedge clk) begin
    started = 1;
    m_rst = rst;
    if (rst) begin
      mph = 0;
      for (int i = 0; i < 8; i++) xs[i] = 0;
      y_cur = 0; y_prev = 0; y_old = 0;
      pk_v = 0; pk_f = 0; pk_a = 0;
      s_v = 0; s_f = 0;
      exp_v = 0; exp_e = 0;
    end else begin
      exp_v = s_v;
      exp_e = (s_v != 0 && s_f != 0) ? s_rd : 0;
      s_v = pk_v; s_f = pk_f; s_rd = lut_m[pk_a];
      pk_v = (mph == 0);
      if (mph == 0) begin                // R5
        pk_f = (y_prev > y_old && y_prev >= y_cur) ? 1 : 0;
        pk_a = pk_f ? y_prev : 0;
        if (pk_f) peaks_seen++;
      end
      if (mph % 2 == 1) begin            // R3
        y_old = y_prev; y_prev = y_cur;
        y_cur = filt(xs[0], xs[1], xs[2], xs[3], xs[4], xs[5], xs[6], xs[7]);
      end else begin                     // R2
        for (int i = 7; i > 0; i--) xs[i] = xs[i-1];
        xs[0] = smp_in;
      end
      mph = (mph + 1) % 4;
    end
    if (cfg_we) begin                    // R8
      if (cfg_addr[11]) begin
        cm[cfg_addr[2:0]] = cfg_wdata[5] ? int'(cfg_wdata[5:0]) - 64 : int'(cfg_wdata[5:0]);
      end else begin
        lut_m[cfg_addr[10:0]] = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (started != 0) begin
      if (m_rst != 0) begin
        checks++;
        if (e_valid !== 1'b0 || energy !== 8'd0) begin
          errors++;
          $display("FAIL R1 reset outputs got v=%0b e=%0d exp v=0 e=0", e_valid, energy);
        end
      end else begin
        checks++;
        if (e_valid !== exp_v[0]) begin
          errors++;
          $display("FAIL R9 e_valid got %0b exp %0d", e_valid, exp_v);
        end
        checks++;
        if (!exp_v[0] && energy !== 8'd0) begin
          errors++;
          $display("FAIL R10 energy outside valid got %0d exp 0", energy);
        end else if (exp_v[0] && energy !== exp_e[7:0]) begin
          errors++;
          $display("FAIL %s %s energy got %0d exp %0d", cur_req,
                   (s_f != 0) ? "R7" : "R6", energy, exp_e);
        end
      end
    end
  end

  int junk = 5;

  task automatic push2x(input int v);
    forever begin
      @(negedge clk);
      if (mph % 2 == 0) begin
        smp_in = v[9:0];
        break;
      end else begin
        junk = (junk * 13 + 7) % 1024;   // R2: ignored odd-phase noise
        smp_in = junk[9:0];
      end
    end
  endtask

  task automatic pulse(input int amp, input int rise, input int flat,
                       input int fall, input int gap);
    for (int i = 1; i <= rise; i++) push2x(amp * i / rise);
    for (int i = 0; i < flat; i++) push2x(amp);
    for (int i = fall - 1; i >= 0; i--) push2x(amp * i / fall);
    for (int i = 0; i < gap; i++) push2x(0);
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = addr[11:0];
    cfg_wdata = data[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coefs(input int c0, c1, c2, c3, c4, c5, c6, c7);
    cfg_write(12'h800, c0 & 63); cfg_write(12'h801, c1 & 63);
    cfg_write(12'h802, c2 & 63); cfg_write(12'h803, c3 & 63);
    cfg_write(12'h804, c4 & 63); cfg_write(12'h805, c5 & 63);
    cfg_write(12'h806, c6 & 63); cfg_write(12'h807, c7 & 63);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (6) @(negedge clk);
    rst = 1'b0;
    // R8: table load, entry 0 nonzero so R6 is visible
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = {1'b0, a[10:0]};
      cfg_wdata = 8'((a * 37 + 90) & 255);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    set_coefs(2, 6, 12, 16, 12, 6, 2, 1);

    cur_req = "R5";                      // slow and fast rising pulses
    pulse(60, 3, 0, 5, 10);
    pulse(200, 9, 0, 8, 10);
    pulse(150, 2, 1, 12, 12);
    cur_req = "R6";                      // plateaus and noise
    pulse(90, 4, 6, 4, 10);
    for (int i = 0; i < 30; i++) push2x((i * 7) % 5);
    cur_req = "R3";                      // single impulse shows coefficient shape
    pulse(100, 1, 0, 1, 14);
    cur_req = "R4";                      // saturation high
    pulse(1023, 2, 3, 2, 12);
    set_coefs(-8, -8, -8, -8, -8, -8, -8, -8);
    pulse(500, 3, 2, 3, 12);             // R4 clamp to zero
    set_coefs(-3, 5, 20, 31, 20, 5, -3, -1);
    cur_req = "R2";
    pulse(300, 5, 0, 7, 10);
    cur_req = "R8";                      // writes while data flows
    fork
      pulse(400, 6, 1, 6, 14);
      begin
        repeat (9) @(negedge clk);
        set_coefs(4, 8, 16, 8, 4, 2, 1, 0);
        for (int a = 0; a < 40; a++) cfg_write(a * 9, 255 - a);
      end
    join
    pulse(250, 4, 0, 4, 12);
    cur_req = "R7";
    pulse(120, 3, 0, 3, 8);
    pulse(777, 5, 0, 9, 12);
    cur_req = "R1";                      // reset mid-pulse clears history
    for (int i = 1; i <= 6; i++) push2x(i * 100);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    smp_in = '0;
    rst = 1'b0;
    for (int i = 0; i < 16; i++) push2x(0);
    pulse(180, 3, 0, 4, 12);
    repeat (8) @(negedge clk);
    checks++;
    if (peaks_seen < 8) begin
      errors++;
      $display("FAIL R5 too few peaks exercised got %0d exp >= 8", peaks_seen);
    end
    finish_run();
  end
endmodule